// File: doc/BRIEF.md
# BCD Real-Time Clock with Indexed Register Access

This block keeps time of day and calendar date as binary-coded decimal bytes. It also holds two control registers and a bank of general-purpose RAM. All of these live in one 128-byte location space. Software reaches that space through two byte-wide ports. It first writes a location number to the index port. It then reads or writes that location through the data port. The index stays latched, so a run of data-port accesses all hit the same location.

A one-cycle `tick` pulse, nominally at 1 Hz, starts an update of the time. The update runs in a state machine with these states:
- `ST_IDLE`: waiting for a tick.
- `ST_LEAD`: the update-in-progress flag is already raised and a lead-in delay of `UIP_LEAD` cycles is counted.
- `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_WDAY`, `ST_MDAY`, `ST_MONTH`, `ST_YEAR`: one state per field. Each of these states writes its field.

The transitions are:
- `ST_IDLE` to `ST_LEAD` on a tick while the freeze bit is clear.
- `ST_LEAD` to `ST_SEC` when the lead counter reaches zero.
- From a field state to the next field state when the current field was at its limit and wraps. Otherwise back to `ST_IDLE`.
- `ST_WDAY` always moves on to `ST_MDAY`, because the hour carry advances both day fields.
- `ST_YEAR` always returns to `ST_IDLE`.

Software sets the freeze bit while it loads a new time. While that bit is set, ticks are ignored.

Top module: `bcd_rtc`

## Requirements
- R1: A write with `io_port`=0 loads the index from `io_wdata[6:0]`, and bit 7 is ignored. The index keeps its value through any number of data-port accesses. Its reset value is 0.
- R2: While `io_cs`=1 and `io_port`=1, `io_rdata` shows the byte at the indexed location. Otherwise it is 0x00. The location map is:
  - 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm
  - 6 day of week, 7 day of month, 8 month, 9 year
  - 10 control A, 11 control B, 12 and 13 status
  - 14 to 127 RAM
- R3: A write with `io_cs`=1, `io_we`=1 and `io_port`=1 stores the full byte in the indexed RAM location (14 to 127), the time/alarm bytes, or control B. Each RAM byte reads back what was last written to it.
- R4: Locations 12 and 13 always read 0x00, and writes to them have no effect.
- R5: Control A bit 7 reads as the update-in-progress flag and cannot be written. Bits 6:0 of control A are read/write. Control B bit 7 is the freeze bit.
- R6: Seconds bit 7 reads 0, and a write to that bit has no effect.
- R7: After reset:
  - time bytes: seconds, minutes and hours 0x00; day of week, day of month and month 0x01; year 0x00
  - alarm bytes, control A, control B and RAM: 0x00
- R8: A tick that the clock edge samples while freeze=0 raises the update-in-progress flag from the next cycle. The flag stays high through `UIP_LEAD` cycles plus one cycle per field written. A tick while freeze=1 causes no update and no flag.
- R9: Each update adds one to seconds. Seconds and minutes wrap from 0x59 to 0x00 and carry to the next field. Hours wrap from 0x23 to 0x00 and carry. The hour carry advances day of week, which wraps from 0x07 to 0x01.
- R10: The hour carry also advances day of month. Day of month wraps to 0x01 after the last day of its month and carries to month:
  - 0x31 for months 1, 3, 5, 7, 8, 10 and 12
  - 0x30 for months 4, 6, 9 and 11
  - 0x29 for February when the year is a multiple of 4, otherwise 0x28

  Month wraps from 0x12 to 0x01 and carries to year. Year wraps from 0x99 to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle update request, nominally once per second |
| io_cs | input | 1 | Access strobe for either port |
| io_port | input | 1 | 0 selects the index port, 1 selects the data port |
| io_we | input | 1 | 1 marks the access as a write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data from the indexed location |

## Verification
A wrong lead counter or a wrong state transition shows up in control A bit 7, one cycle at a time. The flag must be high for exactly `UIP_LEAD`+1 cycles after a tick that carries nothing. So an off-by-one is visible on the data port within a handful of cycles of the tick. A wrong field limit, a broken carry, or a wrong leap-year test leaves a wrong BCD byte. That byte can be read back a few cycles after the update ends. The bench therefore starts from the last second of every month across all hundred years. An index that drifts or takes bit 7 shows up on the very next read as data from the wrong location. The RAM sweep checks this.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam int LOC_W  = 7;
    localparam int BYTE_W = 8;

    localparam logic [LOC_W-1:0] A_SEC   = 7'd0;
    localparam logic [LOC_W-1:0] A_MIN   = 7'd2;
    localparam logic [LOC_W-1:0] A_HOUR  = 7'd4;
    localparam logic [LOC_W-1:0] A_WDAY  = 7'd6;
    localparam logic [LOC_W-1:0] A_MDAY  = 7'd7;
    localparam logic [LOC_W-1:0] A_MONTH = 7'd8;
    localparam logic [LOC_W-1:0] A_YEAR  = 7'd9;
    localparam logic [LOC_W-1:0] A_CTLA  = 7'd10;
    localparam logic [LOC_W-1:0] A_CTLB  = 7'd11;
    localparam logic [LOC_W-1:0] A_RAM0  = 7'd14;
    localparam int               N_TIME  = 10;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LEAD, ST_SEC, ST_MIN, ST_HOUR,
        ST_WDAY, ST_MDAY, ST_MONTH, ST_YEAR
    } upd_state_e;

    typedef enum logic [2:0] {
        FLD_NONE, FLD_SEC, FLD_MIN, FLD_HOUR,
        FLD_WDAY, FLD_MDAY, FLD_MONTH, FLD_YEAR
    } fld_e;

    // Add one to a BCD byte; a low digit of 9 or more carries to the high digit.
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    // Last valid day of the month, in BCD; leap year when year is a multiple of 4.
    function automatic logic [7:0] last_mday(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] m;
        logic [6:0] y;
        m = bcd_to_bin(mon);
        y = bcd_to_bin(yr);
        case (m)
            7'd2:                     return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 8'h30;
            default:                  return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import bcd_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic              io_port,
    input  logic              io_we,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [LOC_W-1:0]  loc_idx,
    output logic              loc_we,
    output logic [BYTE_W-1:0] loc_wdata
);

    logic idx_we;

    assign idx_we    = io_cs && io_we && !io_port;
    assign loc_we    = io_cs && io_we && io_port;
    assign loc_wdata = io_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      loc_idx <= '0;
        else if (idx_we) loc_idx <= io_wdata[LOC_W-1:0];
    end

endmodule

// File: rtl/rtc_update_fsm.sv
module rtc_update_fsm
    import bcd_rtc_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    input  logic at_limit,
    output fld_e step,
    output logic uip
);

    localparam int CW = (UIP_LEAD < 2) ? 1 : $clog2(UIP_LEAD);

    upd_state_e st, st_nx;
    logic [CW-1:0] lead_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                lead_cnt <= '0;
        else if (st == ST_IDLE)                    lead_cnt <= CW'(UIP_LEAD - 1);
        else if (st == ST_LEAD && lead_cnt != '0)  lead_cnt <= lead_cnt - 1'b1;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (tick && !freeze) st_nx = ST_LEAD;
            ST_LEAD:  if (lead_cnt == '0)  st_nx = ST_SEC;
            ST_SEC:   st_nx = at_limit ? ST_MIN   : ST_IDLE;
            ST_MIN:   st_nx = at_limit ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  st_nx = at_limit ? ST_WDAY  : ST_IDLE;
            ST_WDAY:  st_nx = ST_MDAY;
            ST_MDAY:  st_nx = at_limit ? ST_MONTH : ST_IDLE;
            ST_MONTH: st_nx = at_limit ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        step = FLD_NONE;
        uip  = 1'b1;
        unique case (st)
            ST_IDLE:  uip  = 1'b0;
            ST_LEAD:  step = FLD_NONE;
            ST_SEC:   step = FLD_SEC;
            ST_MIN:   step = FLD_MIN;
            ST_HOUR:  step = FLD_HOUR;
            ST_WDAY:  step = FLD_WDAY;
            ST_MDAY:  step = FLD_MDAY;
            ST_MONTH: step = FLD_MONTH;
            ST_YEAR:  step = FLD_YEAR;
            default:  uip  = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
    import bcd_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  loc_idx,
    input  logic              loc_we,
    input  logic [BYTE_W-1:0] loc_wdata,
    input  fld_e              step,
    input  logic              uip,
    output logic              at_limit,
    output logic              freeze,
    output logic [BYTE_W-1:0] sec_now,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] tview [N_TIME];
    logic [BYTE_W-2:0] ctl_a;
    logic [BYTE_W-1:0] ctl_b;
    logic [LOC_W-1:0]  step_addr;
    logic              step_act;
    logic [BYTE_W-1:0] lo_val, hi_val, cur, step_val;

    always_comb begin
        step_act  = 1'b1;
        step_addr = A_SEC;
        lo_val    = 8'h00;
        hi_val    = 8'h59;
        unique case (step)
            FLD_NONE:  step_act = 1'b0;
            FLD_SEC:   step_addr = A_SEC;
            FLD_MIN:   step_addr = A_MIN;
            FLD_HOUR:  begin step_addr = A_HOUR;  hi_val = 8'h23; end
            FLD_WDAY:  begin step_addr = A_WDAY;  lo_val = 8'h01; hi_val = 8'h07; end
            FLD_MDAY:  begin step_addr = A_MDAY;  lo_val = 8'h01;
                             hi_val = last_mday(tview[A_MONTH], tview[A_YEAR]); end
            FLD_MONTH: begin step_addr = A_MONTH; lo_val = 8'h01; hi_val = 8'h12; end
            FLD_YEAR:  begin step_addr = A_YEAR;  hi_val = 8'h99; end
            default:   step_act = 1'b0;
        endcase
        cur      = tview[step_addr[3:0]];
        at_limit = step_act && (cur >= hi_val);
        step_val = at_limit ? lo_val : bcd_next(cur);
    end

    for (genvar i = 0; i < N_TIME; i++) begin : g_tb
        localparam logic [BYTE_W-1:0] RV = (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
        localparam logic [BYTE_W-1:0] WM = (i == 0) ? 8'h7F : 8'hFF;
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= RV;
            else if (loc_we && loc_idx == LOC_W'(i))
                q <= loc_wdata & WM;
            else if (step_act && step_addr == LOC_W'(i))
                q <= step_val;
        end
        assign tview[i] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_a <= '0;
            ctl_b <= '0;
        end else if (loc_we) begin
            if (loc_idx == A_CTLA) ctl_a <= loc_wdata[BYTE_W-2:0];
            if (loc_idx == A_CTLB) ctl_b <= loc_wdata;
        end
    end

    assign freeze  = ctl_b[BYTE_W-1];
    assign sec_now = tview[0];

    always_comb begin
        if (loc_idx < LOC_W'(N_TIME)) rd_data = tview[loc_idx[3:0]];
        else if (loc_idx == A_CTLA)   rd_data = {uip, ctl_a};
        else if (loc_idx == A_CTLB)   rd_data = ctl_b;
        else                          rd_data = '0;
    end

endmodule

// File: rtl/rtc_user_ram.sv
module rtc_user_ram
    import bcd_rtc_pkg::*;
#(
    parameter int BASE = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  loc_idx,
    input  logic              loc_we,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int DEPTH = (1 << LOC_W) - BASE;

    logic [BYTE_W-1:0] view [DEPTH];
    logic [LOC_W-1:0]  off;

    assign off = loc_idx - LOC_W'(BASE);

    for (genvar j = 0; j < DEPTH; j++) begin : g_byte
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     q <= '0;
            else if (loc_we && loc_idx == LOC_W'(BASE + j)) q <= loc_wdata;
        end
        assign view[j] = q;
    end

    always_comb begin
        if (loc_idx >= LOC_W'(BASE)) rd_data = view[off];
        else                         rd_data = '0;
    end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import bcd_rtc_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       io_cs,
    input  logic       io_port,
    input  logic       io_we,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata
);

    logic [LOC_W-1:0]  loc_idx;
    logic              loc_we;
    logic [BYTE_W-1:0] loc_wdata;
    logic [BYTE_W-1:0] bank_rd, ram_rd, sec_now;
    logic              at_limit, freeze, uip;
    fld_e              step;

    rtc_index_port u_idx (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_port(io_port),
        .io_we(io_we), .io_wdata(io_wdata), .loc_idx(loc_idx),
        .loc_we(loc_we), .loc_wdata(loc_wdata)
    );

    rtc_update_fsm #(.UIP_LEAD(UIP_LEAD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
        .at_limit(at_limit), .step(step), .uip(uip)
    );

    rtc_time_bank u_bank (
        .clk(clk), .rst_n(rst_n), .loc_idx(loc_idx), .loc_we(loc_we),
        .loc_wdata(loc_wdata), .step(step), .uip(uip), .at_limit(at_limit),
        .freeze(freeze), .sec_now(sec_now), .rd_data(bank_rd)
    );

    rtc_user_ram #(.BASE(int'(A_RAM0))) u_ram (
        .clk(clk), .rst_n(rst_n), .loc_idx(loc_idx), .loc_we(loc_we),
        .loc_wdata(loc_wdata), .rd_data(ram_rd)
    );

    always_comb begin
        if (io_cs && io_port) io_rdata = (loc_idx < A_RAM0) ? bank_rd : ram_rd;
        else                  io_rdata = '0;
    end

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_cs,
    input logic       io_port,
    input logic       io_we,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic [6:0] loc_idx,
    input logic       uip,
    input logic       freeze,
    input logic [7:0] sec_now
);

    // R1
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cs && io_we && !io_port) |=> $stable(loc_idx));

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && io_we && !io_port) |=> (loc_idx == $past(io_wdata[6:0])));

    // R4
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && io_port && (loc_idx == 7'd12 || loc_idx == 7'd13)) |-> (io_rdata == 8'h00));

    // R6
    sec_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && io_port && loc_idx == 7'd0) |-> !io_rdata[7]);

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !uip) |=> !uip);

    // R8
    sec_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sec_now) && !$past(io_cs && io_we && io_port)) |-> $past(uip));

endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_port(io_port), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .loc_idx(loc_idx), .uip(uip),
    .freeze(freeze), .sec_now(sec_now)
);

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;

    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       io_cs = 1'b0;
    logic       io_port = 1'b0;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc #(.UIP_LEAD(LEAD)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .io_cs(io_cs), .io_port(io_port),
        .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_idx(input logic [7:0] a);
        io_cs = 1'b1; io_port = 1'b0; io_we = 1'b1; io_wdata = a;
        @(negedge clk);
        io_cs = 1'b0; io_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        put_idx(a);
        io_cs = 1'b1; io_port = 1'b1; io_we = 1'b1; io_wdata = v;
        @(negedge clk);
        io_cs = 1'b0; io_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        put_idx(a);
        io_cs = 1'b1; io_port = 1'b1; io_we = 1'b0;
        #1 v = io_rdata;
        io_cs = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (LEAD + 12) @(negedge clk);
    endtask

    task automatic load_time(input logic [7:0] s, mi, h, wd, md, mo, y);
        wr(8'd11, 8'h80);
        wr(8'd0, s); wr(8'd2, mi); wr(8'd4, h);
        wr(8'd6, wd); wr(8'd7, md); wr(8'd8, mo); wr(8'd9, y);
        wr(8'd11, 8'h00);
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b [7];
        rd(8'd0, b[0]); rd(8'd2, b[1]); rd(8'd4, b[2]);
        rd(8'd6, b[3]); rd(8'd7, b[4]); rd(8'd8, b[5]); rd(8'd9, b[6]);
        t = {b[0], b[1], b[2], b[3], b[4], b[5], b[6]};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [55:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state of time, alarm and control bytes
        for (int a = 0; a < 14; a++) begin
            rd(8'(a), v);
            chk($sformatf("R7 reset loc %0d", a), 64'(v),
                64'((a >= 6 && a <= 8) ? 8'h01 : 8'h00));
        end
        rd(8'd100, v);
        chk("R7 reset ram", 64'(v), 64'h00);

        // R2 data port idle returns zero
        put_idx(8'd6);
        #1 chk("R2 rdata idle", 64'(io_rdata), 64'h00);

        // R3 RAM sweep, R1 bit 7 of index ignored
        for (int a = 14; a < 128; a++) wr(8'(a), 8'((a * 37 + 5) & 8'hFF));
        for (int a = 14; a < 128; a++) begin
            rd(8'(a | 128), v);
            chk($sformatf("R3 R1 ram loc %0d", a), 64'(v), 64'((a * 37 + 5) & 8'hFF));
        end

        // R1 index held across repeated data accesses
        put_idx(8'd20);
        io_cs = 1'b1; io_port = 1'b1; io_we = 1'b1; io_wdata = 8'hA1;
        @(negedge clk);
        io_wdata = 8'h5C;
        @(negedge clk);
        io_we = 1'b0;
        #1 chk("R1 index held", 64'(io_rdata), 64'h5C);
        io_cs = 1'b0;
        rd(8'd21, v);
        chk("R1 neighbour untouched", 64'(v), 64'((21 * 37 + 5) & 8'hFF));

        // R4 status registers
        wr(8'd12, 8'hFF); wr(8'd13, 8'hFF);
        rd(8'd12, v); chk("R4 loc 12", 64'(v), 64'h00);
        rd(8'd13, v); chk("R4 loc 13", 64'(v), 64'h00);

        // R5 control A bit 7 read-only, control B full byte
        wr(8'd10, 8'hFF); rd(8'd10, v); chk("R5 ctlA", 64'(v), 64'h7F);
        wr(8'd10, 8'h00);
        wr(8'd11, 8'h6B); rd(8'd11, v); chk("R5 ctlB", 64'(v), 64'h6B);
        wr(8'd11, 8'h00);

        // R6 seconds bit 7
        wr(8'd0, 8'hB5); rd(8'd0, v); chk("R6 sec msb", 64'(v), 64'h35);

        // R8 update-in-progress window for a non-carrying tick
        load_time(8'h10, 8'h20, 8'h05, 8'h03, 8'h14, 8'h06, 8'h21);
        put_idx(8'd10);
        io_cs = 1'b1; io_port = 1'b1; io_we = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        for (int k = 0; k <= LEAD + 1; k++) begin
            if (k > 0) @(negedge clk);
            #1 chk($sformatf("R8 uip cycle %0d", k), 64'(io_rdata[7]), 64'(k <= LEAD));
        end
        io_cs = 1'b0;
        @(negedge clk);
        rd(8'd0, v); chk("R8 R9 sec step", 64'(v), 64'h11);

        // R8 freeze holds time
        wr(8'd11, 8'h80);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        #1 begin put_idx(8'd10); io_cs = 1'b1; io_port = 1'b1; #1 chk("R8 no uip when frozen", 64'(io_rdata[7]), 64'h0); io_cs = 1'b0; end
        repeat (LEAD + 12) @(negedge clk);
        rd(8'd0, v); chk("R8 frozen sec", 64'(v), 64'h11);
        wr(8'd11, 8'h00);

        // R9 minute carry, hour unchanged
        load_time(8'h59, 8'h59, 8'h10, 8'h07, 8'h15, 8'h03, 8'h30);
        do_tick();
        read_time(t);
        chk("R9 minute carry", 64'(t), 64'({8'h00, 8'h00, 8'h11, 8'h07, 8'h15, 8'h03, 8'h30}));

        // R10 not the last day: February 28 of a leap year
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h04);
        do_tick();
        read_time(t);
        chk("R9 R10 leap feb 28", 64'(t), 64'({8'h00, 8'h00, 8'h00, 8'h01, 8'h29, 8'h02, 8'h04}));

        // R9 R10 sweep: last second of every month for every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int d;
                int nm;
                int ny;
                d  = ((m + y) % 7) + 1;
                nm = (m == 12) ? 1 : m + 1;
                ny = (m == 12) ? (y + 1) % 100 : y;
                load_time(8'h59, 8'h59, 8'h23, to_bcd(d), to_bcd(mdays(m, y)), to_bcd(m), to_bcd(y));
                do_tick();
                read_time(t);
                chk($sformatf("R9 R10 rollover y=%0d m=%0d", y, m), 64'(t),
                    64'({8'h00, 8'h00, 8'h00, to_bcd((d == 7) ? 1 : d + 1), 8'h01,
                         to_bcd(nm), to_bcd(ny)}));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule